// File: doc/BRIEF.md
# Real-Time Clock Tick Timer

This block counts a slow periodic enable, nominally 256 pulses per second taken from a 32.768 kHz oscillator divided by 128, in an 8-bit binary counter. Software reads the counter as a divider chain. Bit 0 toggles at 128 Hz and each higher bit toggles at half the rate of the bit below it, so bit 7 toggles at 1 Hz. Four of these taps can raise an interrupt: the 32 Hz, 8 Hz, 2 Hz and 1 Hz taps, which are counter bits 2, 4, 6 and 7.

Each tap has an event flag. A flag sets when its counter bit falls from 1 to 0 as the count advances. The flag latches whatever the state of its enable. Software clears a flag by writing one to it. One interrupt request goes to the system interrupt controller, and it is the OR of every flag whose enable is set. To start the timer, software configures the enables, then clears the counter, then sets the run bit.

The block is reached through a small 2-bit-addressed register port. Writes take effect on a clock edge. Reads are combinational.

Top module: `rtc_tick_timer`

## Requirements
- R1: After system reset the counter, run bit, enables and flags are all 0, and irq_o is low.
- R2: While run is 1, each clock edge that samples tick_i high adds 1 to the counter. The counter wraps from 255 to 0. The count reads back at address 1.
- R3: Flag bits [0], [1], [2] and [3] set when counter bits 2, 4, 6 and 7 (the 32, 8, 2 and 1 Hz taps) fall from 1 to 0 as the count advances. The wrap from 255 to 0 sets all four flags at once.
- R4: While run is 0, ticks are ignored: the counter holds its value and no flag sets.
- R5: Writing a 1 to control bit 1 at address 0 clears the counter at that edge. The bit always reads back as 0. If a tick arrives in the same cycle, the clear wins and no flag sets.
- R6: A flag latches even when its enable (address 2, bits [3:0], same bit order as the flags) is 0. irq_o is high exactly when some flag and its enable are both 1.
- R7: Writing to address 3 clears each flag whose write-data bit is 1 and leaves the flags written with 0 unchanged. If a flag sets and is cleared in the same cycle, it ends up set.
- R8: At address 0, bit 0 is the run bit and can be read and written. A run write changes counting from the next edge onward. Writes to address 1 are ignored. Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 256 Hz count enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Counter, flag and control updates all land on the clock edge that samples tick_i or the write strobe. The new values can be read back, and seen on irq_o, straight after that same edge. A change to an enable reaches irq_o after its write edge with no extra delay. The bench drives every stimulus on the falling clock edge and holds it through exactly one rising edge. It then reads the registers 1 ns after the next falling edge. Every check therefore sees the state one rising edge after its stimulus, which is the cycle in which the result is due. The cases where two things arrive in the same cycle are a tick together with a counter clear, and a flag set together with its clear. Each is driven in one cycle and read back in the next.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        REG_CTRL     = 2'd0,
        REG_COUNT    = 2'd1,
        REG_IRQ_EN   = 2'd2,
        REG_IRQ_FLAG = 2'd3
    } reg_addr_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;

endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_TAP = 4,
    parameter logic [N_TAP-1:0][$clog2(CNT_W)-1:0] TAP_SEL = {3'd7, 3'd6, 3'd4, 3'd2}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [N_TAP-1:0] tap_fall_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv_i) begin
            st_d.cnt = st_q.cnt + ONE;
            step     = 1'b1;
        end
    end

    // per-tap falling edge: bit is 1 now and 0 in the next count
    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        assign tap_fall_o[g] = step & st_q.cnt[TAP_SEL[g]] & ~st_d.cnt[TAP_SEL[g]];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq #(
    parameter int unsigned N_TAP = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_TAP-1:0] set_i,
    input  logic [N_TAP-1:0] clr_i,
    input  logic [N_TAP-1:0] en_i,
    output logic [N_TAP-1:0] flags_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_TAP-1:0] flags;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // a new event outranks a clear written in the same cycle
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & en_i);

endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
    import rtc_tick_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned N_TAP  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [N_TAP-1:0]  flags_i,
    output logic              run_o,
    output logic [N_TAP-1:0]  en_o,
    output logic              cnt_clr_o,
    output logic [N_TAP-1:0]  flag_clr_o
);
    typedef struct packed {
        logic             run;
        logic [N_TAP-1:0] en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    reg_addr_e  sel;

    assign sel = reg_addr_e'(addr_i);

    always_comb begin
        st_d       = st_q;
        cnt_clr_o  = 1'b0;
        flag_clr_o = '0;
        if (we_i) begin
            unique case (sel)
                REG_CTRL: begin
                    st_d.run  = wdata_i[CTRL_RUN_BIT];
                    cnt_clr_o = wdata_i[CTRL_CLR_BIT];
                end
                REG_COUNT:    ;
                REG_IRQ_EN:   st_d.en    = wdata_i[N_TAP-1:0];
                REG_IRQ_FLAG: flag_clr_o = wdata_i[N_TAP-1:0];
                default:      ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_CTRL:     rdata_o[CTRL_RUN_BIT] = st_q.run;
            REG_COUNT:    rdata_o[CNT_W-1:0]    = cnt_i;
            REG_IRQ_EN:   rdata_o[N_TAP-1:0]    = st_q.en;
            REG_IRQ_FLAG: rdata_o[N_TAP-1:0]    = flags_i;
            default:      rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign en_o  = st_q.en;

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned N_TAP  = 4,
    parameter logic [N_TAP-1:0][$clog2(CNT_W)-1:0] TAP_SEL = {3'd7, 3'd6, 3'd4, 3'd2}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic             run;
    logic             cnt_clr;
    logic [N_TAP-1:0] en;
    logic [N_TAP-1:0] flag_clr;
    logic [N_TAP-1:0] flags;
    logic [N_TAP-1:0] tap_fall;
    logic [CNT_W-1:0] cnt;

    rtc_tick_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .N_TAP  (N_TAP)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .cnt_i      (cnt),
        .flags_i    (flags),
        .run_o      (run),
        .en_o       (en),
        .cnt_clr_o  (cnt_clr),
        .flag_clr_o (flag_clr)
    );

    rtc_tick_counter #(
        .CNT_W   (CNT_W),
        .N_TAP   (N_TAP),
        .TAP_SEL (TAP_SEL)
    ) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .adv_i      (tick_i & run),
        .clr_i      (cnt_clr),
        .cnt_o      (cnt),
        .tap_fall_o (tap_fall)
    );

    rtc_tick_irq #(
        .N_TAP (N_TAP)
    ) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (tap_fall),
        .clr_i   (flag_clr),
        .en_i    (en),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_TAP = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             run,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [N_TAP-1:0] flags,
    input logic [N_TAP-1:0] flag_clr,
    input logic [N_TAP-1:0] en,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && tick_i && !cnt_clr) |=> (cnt == $past(cnt) + ONE));

    a_r4_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !cnt_clr) |=> $stable(cnt));

    a_r4_no_flag_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(run && tick_i) || cnt_clr) |=> ((flags & ~$past(flags)) == '0));

    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_clr |=> (cnt == '0));

    a_r6_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags & en) == '0) |-> !irq_o);

    a_r6_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flags & en) != '0) |-> irq_o);

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr == '0) |=> (($past(flags) & ~flags) == '0));

endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(
    .CNT_W (CNT_W),
    .N_TAP (N_TAP)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run      (run),
    .cnt_clr  (cnt_clr),
    .cnt      (cnt),
    .flags    (flags),
    .flag_clr (flag_clr),
    .en       (en),
    .irq_o    (irq_o)
);

// File: tb/rtc_tick_timer_bench.sv
`timescale 1ns/1ps
module rtc_tick_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rtc_tick_timer u_rtc_tick_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // walk table: ticks to apply, expected count, expected flags
    localparam int VN = 8;
    localparam int         V_TICKS [VN] = '{7, 1, 24, 95, 1, 127, 1, 3};
    localparam logic [7:0] V_CNT   [VN] = '{8'd7, 8'd8, 8'd32, 8'd127, 8'd128, 8'd255, 8'd0, 8'd3};
    localparam logic [3:0] V_FLG   [VN] = '{4'h0, 4'h1, 4'h3, 4'h3, 4'h7, 4'h3, 4'hF, 4'h0};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr_tick(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin : watchdog
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 count", v, 8'h00);
        rd(2'd2, v); check("R1 enable", v, 8'h00);
        rd(2'd3, v); check("R1 flags", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R4 ticks while stopped
        ticks(3);
        rd(2'd1, v); check("R4 count held", v, 8'h00);
        rd(2'd3, v); check("R4 no flag", v, 8'h00);

        wr(2'd2, 8'h0F);
        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R8 run readback", v, 8'h01);

        // R2/R3 table walk
        for (int i = 0; i < VN; i++) begin
            ticks(V_TICKS[i]);
            rd(2'd1, v); check($sformatf("R2 count v%0d", i), v, V_CNT[i]);
            rd(2'd3, v); check($sformatf("R3 flags v%0d", i), v, {4'h0, V_FLG[i]});
            check($sformatf("R6 irq v%0d", i), {7'd0, irq}, {7'd0, (V_FLG[i] != 4'h0)});
            wr(2'd3, 8'h0F);
            rd(2'd3, v); check($sformatf("R7 cleared v%0d", i), v, 8'h00);
        end

        // R8 write to count ignored
        wr(2'd1, 8'hAA);
        rd(2'd1, v); check("R8 count write ignored", v, 8'h03);

        // R5 clear bit, reads 0
        wr(2'd0, 8'h03);
        rd(2'd1, v); check("R5 cleared", v, 8'h00);
        rd(2'd0, v); check("R5 clear reads 0", v, 8'h01);

        // R5 clear beats tick on the wrap
        ticks(255);
        rd(2'd1, v); check("R5 at 255", v, 8'hFF);
        wr(2'd3, 8'h0F);
        wr_tick(2'd0, 8'h03);
        rd(2'd1, v); check("R5 clear priority count", v, 8'h00);
        rd(2'd3, v); check("R5 clear priority flags", v, 8'h00);

        // R6 flag latches with enable off
        wr(2'd2, 8'h00);
        ticks(8);
        rd(2'd3, v); check("R6 flag latched", v, 8'h01);
        check("R6 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h01);
        check("R6 irq enabled", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h02);
        check("R6 irq other enable", {7'd0, irq}, 8'h00);

        // R7 partial clear and set-wins
        ticks(24);
        rd(2'd3, v); check("R7 two flags", v, 8'h03);
        check("R6 irq on bit1", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h02);
        rd(2'd3, v); check("R7 partial clear", v, 8'h01);
        wr(2'd3, 8'h01);
        ticks(7);
        rd(2'd1, v); check("R2 count 39", v, 8'd39);
        wr_tick(2'd3, 8'h01);
        rd(2'd3, v); check("R7 set wins", v, 8'h01);

        // R8 run write effective next edge: stop then tick
        wr_tick(2'd0, 8'h00);
        rd(2'd1, v); check("R8 tick with stop write", v, 8'd41);
        ticks(2);
        rd(2'd1, v); check("R4 stopped again", v, 8'd41);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd1, v); check("R1 count after reset", v, 8'h00);
        rd(2'd3, v); check("R1 flags after reset", v, 8'h00);
        rd(2'd0, v); check("R1 run after reset", v, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule